// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an internal request port and an external 8K x 8 asynchronous static RAM that has two chip enables, one active low and one active high. It takes one request at a time through a valid/ready handshake. Each request is a single-byte read or write. The controller turns it into a strobe sequence for the memory, with every interval counted in clock cycles.

The interval lengths come from parameters given in picoseconds, together with the clock period. Each interval is rounded up to whole cycles, and no interval is shorter than one cycle. A read holds the device selected with output enable asserted for the whole access time. It captures the bus on the last cycle of that time and returns the byte with a one-cycle response pulse.

A write goes through three phases: address setup, a write pulse during which the controller drives the bus, and recovery. The controller never drives the bus while the memory's output enable is asserted. After a read, the write data is held back until the memory's output drivers have had time to turn off.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, both chip enables are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_rw`=1 (1 = read, 0 = write), `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only when the controller is idle. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. A request held while the controller is busy has no effect on the strobes until it is accepted.
- R3: A read occupies the N_ACC cycles that follow acceptance. In those cycles the device is selected (`mem_sel_n`=0, `mem_sel`=1), `mem_oe_n`=0, `mem_rw`=1 and `mem_dq_oe`=0.
- R4: The read byte is captured from `mem_dq_in` on the last access cycle. It appears on `rsp_rdata` in the following cycle, with `rsp_valid` high for exactly that one cycle.
- R5: A write first spends at least N_AS cycles in setup. In setup the device is selected, `mem_rw`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R6: The write pulse lasts N_PULSE cycles, where N_PULSE is the largest of the write-pulse, data-setup and select-to-end counts. In the pulse the device is selected, `mem_rw`=0, `mem_oe_n`=1, `mem_dq_oe`=1, and `mem_dq_out` carries the request data.
- R7: Recovery follows the pulse and lasts N_WR cycles, with the device deselected and `mem_rw`=1. `mem_dq_oe` stays high only in the first recovery cycle. The controller is idle after recovery.
- R8: Once `mem_oe_n` has risen after a read, `mem_dq_oe` does not rise again until more than N_OFF cycles later. The setup phase is stretched as needed to meet this.
- R9: `mem_dq_oe` and an asserted `mem_oe_n` (low) never occur in the same cycle.
- R10: Every interval count equals the parameter time divided by `CLK_PS`, rounded up, with a minimum of 1. This applies to access, setup, pulse, recovery and turnaround.
- R11: `mem_addr` shows the address of the request being served and does not change while the device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 13 | Memory address |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
The bench builds the controller with a 4000 ps clock and the following times: access 18000 ps, write pulse 9000 ps, data setup 5000 ps, select-to-end 14000 ps, setup and recovery 0 ps, and turnaround 10000 ps. These values give an access of 5 cycles rounded up from 4.5 and a pulse of 4 cycles set by the select-to-end rule rather than the pulse width. Setup and recovery are clamped to one cycle. The 3-cycle turnaround is longer than setup, so a write that follows a read sees its setup stretched, while a write issued long after a read does not. The bench's memory model returns valid data only on the last access cycle, so capturing the read byte one cycle early returns the wrong value.

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl #(
  parameter int CLK_PS   = 10000,
  parameter int T_ACC_PS = 100000,
  parameter int T_WP_PS  = 60000,
  parameter int T_DS_PS  = 40000,
  parameter int T_CW_PS  = 80000,
  parameter int T_AS_PS  = 0,
  parameter int T_WR_PS  = 0,
  parameter int T_OFF_PS = 35000,
  parameter int AW       = 13,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_rw,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int t);
    int n;
    n = (t + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int N_ACC   = cyc(T_ACC_PS);
  localparam int N_AS    = cyc(T_AS_PS);
  localparam int N_WR    = cyc(T_WR_PS);
  localparam int N_OFF   = cyc(T_OFF_PS);
  localparam int N_PULSE = max3(cyc(T_WP_PS), cyc(T_DS_PS), cyc(T_CW_PS));
  localparam int N_MAX   = max3(max3(N_ACC, N_AS, N_WR), N_PULSE, 1);
  localparam int CW      = $clog2(N_MAX + 1);
  localparam int QW      = $clog2(N_OFF + 1);

  typedef enum logic [2:0] {IDLE, READ, SETUP, PULSE, RECOV} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [QW-1:0] quiet;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;

  assign req_ready  = (ph == IDLE);
  assign mem_sel_n  = !(ph == READ || ph == SETUP || ph == PULSE);
  assign mem_sel    = !mem_sel_n;
  assign mem_oe_n   = (ph != READ);
  assign mem_rw     = (ph != PULSE);
  assign mem_dq_oe  = (ph == PULSE) || (ph == RECOV && cnt == CW'(N_WR - 1));
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      quiet   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (quiet != '0) quiet <= quiet - 1'b1;
      case (ph)
        IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            ph  <= SETUP;
            cnt <= CW'(N_AS - 1);
          end else begin
            ph  <= READ;
            cnt <= CW'(N_ACC - 1);
          end
        end
        READ: if (cnt == '0) begin
          rdata_q <= mem_dq_in;
          rsp_q   <= 1'b1;
          quiet   <= QW'(N_OFF);
          ph      <= IDLE;
        end else cnt <= cnt - 1'b1;
        SETUP: if (cnt == '0 && quiet == '0) begin
          ph  <= PULSE;
          cnt <= CW'(N_PULSE - 1);
        end else if (cnt != '0) cnt <= cnt - 1'b1;
        PULSE: if (cnt == '0) begin
          ph  <= RECOV;
          cnt <= CW'(N_WR - 1);
        end else cnt <= cnt - 1'b1;
        RECOV: if (cnt == '0) ph <= IDLE;
          else cnt <= cnt - 1'b1;
        default: ph <= IDLE;
      endcase
    end
  end

  assert_bus_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_oe_n && mem_rw));
  assert_pulse_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rw |-> (mem_dq_oe && !mem_sel_n && mem_sel && mem_oe_n));
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |=> (mem_sel_n || $stable(mem_addr)));
  assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_rw && mem_sel));

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;
  localparam int CLK_PS = 4000, T_ACC = 18000, T_WP = 9000, T_DS = 5000;
  localparam int T_CW = 14000, T_AS = 0, T_WR = 0, T_OFF = 10000;

  function automatic int up(input int t);
    int n;
    n = (t + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  int NACC, NAS, NWR, NOFF, NP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [12:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_sel_n, mem_sel, mem_oe_n, mem_rw, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [12:0] mem_addr;

  sram_strobe_ctrl #(.CLK_PS(CLK_PS), .T_ACC_PS(T_ACC), .T_WP_PS(T_WP), .T_DS_PS(T_DS),
    .T_CW_PS(T_CW), .T_AS_PS(T_AS), .T_WR_PS(T_WR), .T_OFF_PS(T_OFF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_rw(mem_rw),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #2 clk = ~clk;

  // external memory: data valid only on the last access cycle
  logic [7:0] sram [0:8191];
  int rdcnt = 0;
  wire reading = !mem_sel_n && mem_sel && !mem_oe_n && mem_rw;
  assign mem_dq_in = (reading && rdcnt >= NACC - 1) ? sram[mem_addr] : 8'hA5;
  always @(posedge clk) begin
    rdcnt <= reading ? rdcnt + 1 : 0;
    if (!mem_sel_n && mem_sel && !mem_rw) sram[mem_addr] <= mem_dq_out;
  end

  // reference model: 0 idle, 1 read, 2 setup, 3 pulse, 4 recovery
  int m_ph = 0, m_age = 0, m_quiet = 0;
  logic [12:0] m_addr = '0;
  logic [7:0] m_data = '0, m_rdata = '0;
  logic m_rsp = 0;
  logic [7:0] shadow [0:8191];

  always @(posedge clk) begin
    int nq;
    if (!rst_n) begin
      m_ph = 0; m_age = 0; m_quiet = 0; m_addr = '0; m_data = '0; m_rdata = '0; m_rsp = 0;
    end else begin
      m_rsp = 0;
      nq = (m_quiet > 0) ? m_quiet - 1 : 0;
      case (m_ph)
        0: if (req_valid) begin
          m_addr = req_addr; m_data = req_wdata; m_age = 0;
          m_ph = req_write ? 2 : 1;
        end
        1: if (m_age == NACC - 1) begin
          m_rdata = shadow[m_addr]; m_rsp = 1; m_ph = 0; nq = NOFF;
        end else m_age++;
        2: if (m_age >= NAS - 1 && m_quiet == 0) begin m_ph = 3; m_age = 0; end
           else m_age++;
        3: if (m_age == NP - 1) begin shadow[m_addr] = m_data; m_ph = 4; m_age = 0; end
           else m_age++;
        default: if (m_age == NWR - 1) m_ph = 0; else m_age++;
      endcase
      m_quiet = nq;
    end
  end

  int vectors = 0, miscompares = 0;
  task automatic chk(input string req, input string name, input logic [15:0] act,
                     input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, name, act, exp, $time);
    end
  endtask

  int off_age = 1000, rd_len = 0, wp_len = 0;
  logic prev_oe_n = 1, prev_rw = 1, prev_dqoe = 0;

  always @(negedge clk) begin
    string t;
    logic e_seln, e_oen, e_rw, e_dqoe;
    case (m_ph)
      0: begin t = "R1"; e_seln = 1; e_oen = 1; e_rw = 1; e_dqoe = 0; end
      1: begin t = "R3"; e_seln = 0; e_oen = 0; e_rw = 1; e_dqoe = 0; end
      2: begin t = "R5"; e_seln = 0; e_oen = 1; e_rw = 1; e_dqoe = 0; end
      3: begin t = "R6"; e_seln = 0; e_oen = 1; e_rw = 0; e_dqoe = 1; end
      default: begin t = "R7"; e_seln = 1; e_oen = 1; e_rw = 1; e_dqoe = (m_age == 0); end
    endcase
    chk(t, "sel_n", 16'(mem_sel_n), 16'(e_seln));
    chk(t, "sel", 16'(mem_sel), 16'(!e_seln));
    chk(t, "oe_n", 16'(mem_oe_n), 16'(e_oen));
    chk(t, "rw", 16'(mem_rw), 16'(e_rw));
    chk(t, "dq_oe", 16'(mem_dq_oe), 16'(e_dqoe));
    chk("R2", "ready", 16'(req_ready), 16'(m_ph == 0));
    chk("R4", "rsp_valid", 16'(rsp_valid), 16'(m_rsp));
    if (m_rsp) chk("R4", "rsp_rdata", 16'(rsp_rdata), 16'(m_rdata));
    if (m_ph != 0) chk("R11", "addr", 16'(mem_addr), 16'(m_addr));
    if (m_ph == 3) chk("R6", "dq_out", 16'(mem_dq_out), 16'(m_data));
    if (mem_dq_oe) chk("R9", "oe_n while driving", 16'(mem_oe_n), 16'd1);
    // R8: turnaround measured at the pins
    off_age = mem_oe_n ? off_age + 1 : 0;
    if (mem_dq_oe && !prev_dqoe) chk("R8", "turnaround ok", 16'(off_age > NOFF), 16'd1);
    // R10: measured strobe lengths
    if (!mem_oe_n) rd_len++;
    else if (!prev_oe_n) begin chk("R10", "read length", 16'(rd_len), 16'(NACC)); rd_len = 0; end
    if (!mem_rw) wp_len++;
    else if (!prev_rw) begin chk("R10", "pulse length", 16'(wp_len), 16'(NP)); wp_len = 0; end
    prev_oe_n = mem_oe_n; prev_rw = mem_rw; prev_dqoe = mem_dq_oe;
  end

  task automatic do_req(input logic w, input logic [12:0] a, input logic [7:0] d);
    logic ok;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk);
    end while (!ok);
    #1 req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  bit done = 0;
  initial begin
    NACC = up(T_ACC); NAS = up(T_AS); NWR = up(T_WR); NOFF = up(T_OFF);
    NP = up(T_WP);
    if (up(T_DS) > NP) NP = up(T_DS);
    if (up(T_CW) > NP) NP = up(T_CW);
    chk("R10", "access count", 16'(NACC), 16'd5);
    chk("R10", "pulse count", 16'(NP), 16'd4);
    idle(3);
    rst_n = 1;
    idle(2);
    do_req(1, 13'h0000, 8'h3C);
    do_req(1, 13'h1FFF, 8'hC3);
    do_req(1, 13'h0A5A, 8'h5A);
    do_req(1, 13'h1234, 8'hFF);
    do_req(0, 13'h0000, 8'h00);
    do_req(0, 13'h1FFF, 8'h00);
    do_req(0, 13'h0A5A, 8'h00);
    do_req(0, 13'h1234, 8'h00);
    do_req(1, 13'h0A5A, 8'h81);   // write right after read: stretched setup (R8)
    do_req(0, 13'h0A5A, 8'h00);
    idle(1);
    do_req(1, 13'h0100, 8'h7E);   // one idle cycle after read
    do_req(0, 13'h0100, 8'h00);
    idle(12);
    do_req(1, 13'h0001, 8'h00);   // long gap: plain setup
    do_req(0, 13'h0001, 8'h00);
    idle(2);
    do_req(1, 13'h1555, 8'h96);
    do_req(0, 13'h1555, 8'h00);
    idle(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule